// File: doc/BRIEF.md
# Four-Requester Priority Bus Arbiter

This block decides which of four devices drives a shared bus in each clock period. Each device raises its request line while it wants the bus. The arbiter answers with one-hot grant lines, and never asserts more than one grant at a time. When several devices compete, the device with the lowest index wins. The grants are decoded from a registered five-state machine: one idle state, plus one owner state for each device. A grant therefore appears on the clock edge after the request that earned it. Between edges the grants do not move.

A policy input chooses how a current owner is treated. In preemptive policy, the owner loses the bus as soon as a device with a lower index requests it. In hold policy, the owner keeps the bus until it lowers its own request, whatever the other devices ask for. The policy is read on every edge, so a change applies to the next decision only. When the owner releases the bus, the arbiter moves to the best pending requester, or returns to idle if there is none.

Top module: `bus_arbiter`

## Requirements
- R1: At most one bit of `gnt_o` is 1 in any clock period. Bit k set means device k owns the bus.
- R2: While `rst_n` is low, all grants are 0. After reset is released, the arbiter starts in idle.
- R3: When no request was asserted at an edge, all grants are 0 after that edge, under either policy.
- R4: From idle, the lowest-index asserted request is granted on the next clock edge.
- R5: With `preempt_i` = 1, an asserted request with a lower index than the owner moves the grant to that device on the next edge.
- R6: With `preempt_i` = 0, an owner whose request is still asserted keeps its grant across the edge, regardless of other requests.
- R7: When the owner's request is low at an edge, the grant moves to the lowest-index pending requester, or all grants go to 0 if none is pending.
- R8: The grants change only at clock edges. A change of `req_i` or `preempt_i` between edges leaves `gnt_o` unchanged until the next edge.
- R9: A change of `preempt_i` during an ownership affects only the decision at the following edge. The next grant follows R5 or R6 according to the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_i | input | 4 | Request lines; bit k belongs to device k |
| preempt_i | input | 1 | Policy: 1 = preemptive, 0 = hold until release |
| gnt_o | output | 4 | One-hot grant lines; bit k belongs to device k |

## Verification
Owner release and a competing request can fall in the same cycle. So can a policy change and a higher-priority request arriving during an ownership. The bench provokes these cases in three ways:
- It lowers the owner's request on the same edge on which other devices raise theirs.
- It flips `preempt_i` on the edge on which a lower-index device starts requesting.
- It holds the owner's request while the policy toggles.

A behavioural reference model computes the owner from the sampled requests and policy. The bench compares the model's owner with the grant outputs after every edge, and checks between edges that the grants have not moved.

// File: rtl/arb_pkg.sv
package arb_pkg;
  parameter int unsigned ARB_N = 4;
  localparam int unsigned ARB_IW = (ARB_N > 1) ? $clog2(ARB_N) : 1;

  typedef enum logic {
    POL_HOLD    = 1'b0,
    POL_PREEMPT = 1'b1
  } arb_policy_e;

  typedef struct packed {
    logic              busy;
    logic [ARB_IW-1:0] owner;
  } arb_state_t;
endpackage

// File: rtl/arb_prio_pick.sv
module arb_prio_pick #(
  parameter int unsigned N  = 4,
  parameter int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  // Scan from the top index down, so the lowest set index is written last.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/arb_next_state.sv
module arb_next_state
  import arb_pkg::*;
#(
  parameter int unsigned N  = ARB_N,
  parameter int unsigned IW = ARB_IW
) (
  input  logic        cur_busy,
  input  logic [IW-1:0] cur_owner,
  input  logic [N-1:0]  req,
  input  arb_policy_e   policy,
  output logic          nxt_busy,
  output logic [IW-1:0] nxt_owner
);
  logic          any_req;
  logic [IW-1:0] best_idx;
  logic          owner_still;
  logic          keep_owner;

  arb_prio_pick #(.N(N), .IW(IW)) u_pick (
    .req   (req),
    .found (any_req),
    .idx   (best_idx)
  );

  assign owner_still = cur_busy && req[cur_owner];
  assign keep_owner  = owner_still && (policy == POL_HOLD);

  always_comb begin
    if (keep_owner) begin
      nxt_busy  = 1'b1;
      nxt_owner = cur_owner;
    end else if (any_req) begin
      nxt_busy  = 1'b1;
      nxt_owner = best_idx;
    end else begin
      nxt_busy  = 1'b0;
      nxt_owner = '0;
    end
  end
endmodule

// File: rtl/arb_grant_decode.sv
module arb_grant_decode #(
  parameter int unsigned N  = 4,
  parameter int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          busy,
  input  logic [IW-1:0] owner,
  output logic [N-1:0]  gnt
);
  for (genvar k = 0; k < N; k++) begin : g_dec
    assign gnt[k] = busy && (owner == IW'(k));
  end
endmodule

// File: rtl/bus_arbiter.sv
module bus_arbiter
  import arb_pkg::*;
#(
  parameter int unsigned N_REQ = ARB_N
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_REQ-1:0] req_i,
  input  logic             preempt_i,
  output logic [N_REQ-1:0] gnt_o
);
  localparam int unsigned IW = (N_REQ > 1) ? $clog2(N_REQ) : 1;

  logic          st_busy_q, st_busy_d;
  logic [IW-1:0] st_owner_q, st_owner_d;
  logic          st_en;
  arb_policy_e   policy;

  assign policy = preempt_i ? POL_PREEMPT : POL_HOLD;

  arb_next_state #(.N(N_REQ), .IW(IW)) u_next (
    .cur_busy  (st_busy_q),
    .cur_owner (st_owner_q),
    .req       (req_i),
    .policy    (policy),
    .nxt_busy  (st_busy_d),
    .nxt_owner (st_owner_d)
  );

  // Clock enable: load the state register only when the state changes.
  assign st_en = (st_busy_d != st_busy_q) || (st_owner_d != st_owner_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_busy_q  <= 1'b0;
      st_owner_q <= '0;
    end else if (st_en) begin
      st_busy_q  <= st_busy_d;
      st_owner_q <= st_owner_d;
    end
  end

  arb_grant_decode #(.N(N_REQ), .IW(IW)) u_dec (
    .busy  (st_busy_q),
    .owner (st_owner_q),
    .gnt   (gnt_o)
  );

  AST_GNT_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt_o)); // R1
  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |-> (gnt_o == '0)); // R2
  AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (req_i == '0) |=> (gnt_o == '0)); // R3
  AST_IDLE_LOWEST: assert property (@(posedge clk) disable iff (!rst_n) ((gnt_o == '0) && (req_i != '0)) |=> (gnt_o == ($past(req_i) & (-$past(req_i))))); // R4
  AST_PREEMPT_LOWEST: assert property (@(posedge clk) disable iff (!rst_n) (preempt_i && (req_i != '0)) |=> (gnt_o == ($past(req_i) & (-$past(req_i))))); // R5
  AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (!rst_n) (!preempt_i && ((gnt_o & req_i) != '0)) |=> (gnt_o == $past(gnt_o))); // R6
  AST_RELEASE_NEXT: assert property (@(posedge clk) disable iff (!rst_n) ((gnt_o != '0) && ((gnt_o & req_i) == '0)) |=> (gnt_o == ($past(req_i) & (-$past(req_i))))); // R7
  AST_GNT_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n) (gnt_o != '0) |-> ((gnt_o & $past(req_i)) == gnt_o)); // R9
endmodule

// File: tb/sim_bus_arbiter.sv
module sim_bus_arbiter;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] req;
  logic       pre;
  logic [3:0] gnt;

  int checks = 0;
  int errors = 0;
  int owner  = -1;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  bus_arbiter u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (req),
    .preempt_i (pre),
    .gnt_o     (gnt)
  );

  function automatic int ref_next(int own, logic [3:0] r, logic p);
    if (own >= 0 && !p && r[own]) return own;
    for (int i = 0; i < 4; i++) if (r[i]) return i;
    return -1;
  endfunction

  function automatic logic [3:0] ref_gnt(int own);
    return (own < 0) ? 4'b0000 : 4'(1 << own);
  endfunction

  task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: gnt actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // Called at a negedge: drive the inputs, let one edge pass, check at the next negedge.
  task automatic step(logic [3:0] r, logic p, string tag);
    int nxt;
    req = r;
    pre = p;
    nxt = ref_next(owner, r, p);
    #1 check({"R8 between edges (", tag, ")"}, gnt, ref_gnt(owner));
    @(posedge clk);
    owner = nxt;
    @(negedge clk);
    check(tag, gnt, ref_gnt(owner));
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    req   = 4'b1111;
    pre   = 1'b1;
    repeat (3) @(negedge clk);
    check("R2 reset", gnt, 4'b0000);
    rst_n = 1'b1;
    owner = -1;

    step(4'b0000, 1'b0, "R3 idle hold");
    step(4'b0000, 1'b1, "R3 idle preempt");
    step(4'b1010, 1'b0, "R4 idle picks 1");
    step(4'b1011, 1'b0, "R6 owner 1 kept vs 0");
    step(4'b1110, 1'b0, "R6 owner 1 kept vs 2,3");
    step(4'b1101, 1'b0, "R7 release to 0");
    step(4'b0101, 1'b1, "R5 preempt keeps 0");
    step(4'b1100, 1'b1, "R7 release to 2");
    step(4'b1101, 1'b1, "R5 preempt 2 by 0");
    step(4'b1000, 1'b0, "R7 release to 3");
    step(4'b1010, 1'b0, "R6 owner 3 kept");
    step(4'b1010, 1'b1, "R9 switch to preempt");
    step(4'b1011, 1'b0, "R9 back to hold");
    step(4'b0001, 1'b1, "R1 single grant");
    step(4'b0000, 1'b0, "R7 release to idle");
    step(4'b1000, 1'b1, "R4 idle picks 3");
    step(4'b1100, 1'b1, "R5 preempt 3 by 2");

    // Random mix under both policies, compared with the model every cycle.
    for (int n = 0; n < 300; n++) begin
      logic [3:0] r;
      logic p;
      r = 4'($urandom_range(0, 15));
      p = 1'($urandom_range(0, 1));
      step(r, p, "R1 R5 R6 R7 random");
      checks++;
      if (!$onehot0(gnt)) begin
        errors++;
        $display("FAIL R1: gnt actual %b expected one-hot or zero", gnt);
      end
    end

    // Reset in the middle of an ownership.
    req = 4'b0100;
    rst_n = 1'b0;
    #1 check("R2 reset mid-ownership", gnt, 4'b0000);
    @(negedge clk);
    rst_n = 1'b1;
    owner = -1;
    step(4'b0100, 1'b0, "R4 after reset");

    finish_run();
  end
endmodule